// File: doc/BRIEF.md
# One-Hot Diagonal Shift and Rotate Crossbar

This block moves an N-bit word left, right or around in a single combinational pass. It is organised as a crossbar in which every output bit is joined to exactly one input bit, or to a bit of a literal word. The connection is chosen by a one-hot select vector with one line per diagonal of the crossbar. A full crossbar would need one control per input/output pair. Here a whole diagonal of switches is enabled by a single line, so only 2N-1 lines exist for shifting and N lines for rotation.

In shift mode a bit pushed past either end of the word is lost. Each vacated output position is filled from the same position of the literal word, so a zero literal gives a logical shift. In rotate mode the two halves of each diagonal are joined at the wrap point, so bits leaving one end come back at the other.

The select vector can come straight from the ports, or from a small front end. The front end registers a signed binary shift amount and turns it into the one-hot vector. A select that is not a legal one-hot pattern raises an error flag and forces the output to zero. So does a decoded amount outside the reachable range.

Top module: `xbar_diag_shifter`

## Requirements
- R1: In shift mode (`rot_i`=0), select line index N-1+s with 1<=s<=N-1 shifts left by s. Output bit y equals `data_i[y-s]` for y>=s and `lit_i[y]` for y<s.
- R2: In shift mode, select line index N-1-m with 1<=m<=N-1 shifts right by m. Output bit y equals `data_i[y+m]` for y<N-m and `lit_i[y]` for y>=N-m.
- R3: In shift mode, select line index N-1 alone passes `data_i` to `data_o` unchanged.
- R4: In rotate mode (`rot_i`=1), select line index r with 0<=r<=N-1 rotates `data_i` left by r, with output bit y equal to `data_i[(y-r) mod N]`. `lit_i` has no effect in this mode.
- R5: When the select in use has no bit set or more than one bit set, `err_o` is 1 and `data_o` is all zeros. The same holds when rotate mode is selected and any line with index N or above is set.
- R6: With `use_dec_i`=1, `sel_i` is ignored. The signed amount on `amt_i` is captured at a rising clock edge and then acts as shift amount a (positive = left) or as left rotation by a mod N. The result appears in the cycle after the edge.
- R7: A captured amount outside -(N-1)..+(N-1) sets `err_o` and drives `data_o` to zero in both modes.
- R8: While `rst_n` is low, the captured amount is 0, so with `use_dec_i`=1 and shift mode `data_o` equals `data_i` and `err_o` is 0.
- R9: The path from `sel_i`, `data_i`, `lit_i` and `rot_i` to the outputs is combinational. A change is visible without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the amount register |
| rst_n | input | 1 | Asynchronous active-low reset of the amount register |
| data_i | input | N | Word to shift or rotate |
| lit_i | input | N | Literal word supplying vacated positions in shift mode |
| rot_i | input | 1 | 0 = shift mode, 1 = rotate mode |
| use_dec_i | input | 1 | 1 = take the select from the decoded amount, 0 = from `sel_i` |
| sel_i | input | 2N-1 | External one-hot diagonal select |
| amt_i | input | AMT_W | Signed binary amount for the decoder front end |
| data_o | output | N | Shifted or rotated word |
| err_o | output | 1 | Select not one-hot, or decoded amount out of range |

## Verification
Several properties are checked on every cycle. A raised error always comes with a zero word. The zero diagonal is an identity in shift mode, and a one-place shift moves each bit by exactly one position and takes the vacated bit from the literal. A rotation keeps the population count of the word. The decoder yields exactly one select line for every in-range amount, and an out-of-range amount always reaches the error output. The full bit pattern for each diagonal and the literal fill at multi-place distances are shown only by the bench scenarios. So are the exact values at the wrap point, the combinational timing of the external path, the one-cycle latency of the decoded path and the value held under reset.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic {
    MODE_SHIFT  = 1'b0,
    MODE_ROTATE = 1'b1
  } xbar_mode_e;
endpackage

// File: rtl/xbar_amt_decoder.sv
module xbar_amt_decoder
  import xbar_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int AMT_W = $clog2(WIDTH) + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [AMT_W-1:0] amt_i,
  input  xbar_mode_e              mode_i,
  output logic [2*WIDTH-2:0]      vec_o,
  output logic                    range_err_o
);
  localparam int NSEL  = 2 * WIDTH - 1;
  localparam int IDX_W = $clog2(NSEL);

  logic signed [AMT_W-1:0] amt_q;

  // Only this register sits in front of the crossbar.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) amt_q <= '0;
    else        amt_q <= amt_i;
  end

  function automatic logic amt_in_range(input int a);
    return (a >= -(WIDTH - 1)) && (a <= WIDTH - 1);
  endfunction

  function automatic logic [IDX_W-1:0] shift_line(input int a);
    return IDX_W'(a + WIDTH - 1);
  endfunction

  function automatic logic [IDX_W-1:0] rotate_line(input int a);
    return (a < 0) ? IDX_W'(a + WIDTH) : IDX_W'(a);
  endfunction

  int          amt_int;
  logic        in_range;
  logic [IDX_W-1:0] line_idx;

  always_comb begin
    amt_int  = int'(amt_q);
    in_range = amt_in_range(amt_int);
    line_idx = (mode_i == MODE_ROTATE) ? rotate_line(amt_int) : shift_line(amt_int);
    vec_o    = in_range ? (NSEL'(1) << line_idx) : '0;
  end

  assign range_err_o = !in_range;

  // R6: every in-range captured amount selects exactly one diagonal
  assert_dec_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !range_err_o |-> ($countones(vec_o) == 1));
endmodule

// File: rtl/xbar_sel_check.sv
module xbar_sel_check
  import xbar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [2*WIDTH-2:0] vec_i,
  input  xbar_mode_e         mode_i,
  output logic               sel_ok_o
);
  localparam int NSEL = 2 * WIDTH - 1;

  logic exactly_one;
  logic upper_clear;

  assign exactly_one = ($countones(vec_i) == 1);
  // Rotate mode only has the WIDTH joined diagonals at the bottom of the vector.
  assign upper_clear = (vec_i[NSEL-1:WIDTH] == '0);
  assign sel_ok_o    = exactly_one && ((mode_i == MODE_SHIFT) || upper_clear);
endmodule

// File: rtl/xbar_diag_array.sv
module xbar_diag_array
  import xbar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   data_i,
  input  logic [WIDTH-1:0]   lit_i,
  input  logic [2*WIDTH-2:0] sel_i,
  input  xbar_mode_e         mode_i,
  output logic [WIDTH-1:0]   net_o
);
  localparam int NSEL = 2 * WIDTH - 1;

  logic [NSEL-1:0]  sh_term [WIDTH];
  logic [WIDTH-1:0] rt_term [WIDTH];
  logic [WIDTH-1:0] sh_out;
  logic [WIDTH-1:0] rt_out;

  for (genvar y = 0; y < WIDTH; y++) begin : g_out
    // Shift diagonals: line k moves input bit (y - (k-(WIDTH-1))) to output y.
    for (genvar k = 0; k < NSEL; k++) begin : g_shdiag
      localparam int SRC = y - k + (WIDTH - 1);
      if (SRC >= 0 && SRC < WIDTH) begin : g_data
        assign sh_term[y][k] = sel_i[k] & data_i[SRC];
      end else begin : g_fill
        assign sh_term[y][k] = sel_i[k] & lit_i[y];
      end
    end
    // Joined diagonals: line r wraps the word by r places.
    for (genvar r = 0; r < WIDTH; r++) begin : g_rtdiag
      localparam int RSRC = (y - r + WIDTH) % WIDTH;
      assign rt_term[y][r] = sel_i[r] & data_i[RSRC];
    end
    assign sh_out[y] = |sh_term[y];
    assign rt_out[y] = |rt_term[y];
  end

  assign net_o = (mode_i == MODE_ROTATE) ? rt_out : sh_out;
endmodule

// File: rtl/xbar_diag_shifter.sv
module xbar_diag_shifter
  import xbar_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int AMT_W = $clog2(WIDTH) + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WIDTH-1:0]        data_i,
  input  logic [WIDTH-1:0]        lit_i,
  input  logic                    rot_i,
  input  logic                    use_dec_i,
  input  logic [2*WIDTH-2:0]      sel_i,
  input  logic signed [AMT_W-1:0] amt_i,
  output logic [WIDTH-1:0]        data_o,
  output logic                    err_o
);
  localparam int NSEL = 2 * WIDTH - 1;
  localparam int ZERO_LINE = WIDTH - 1;

  xbar_mode_e      mode;
  logic [NSEL-1:0] dec_vec;
  logic            dec_range_err;
  logic [NSEL-1:0] sel_used;
  logic            sel_ok;
  logic [WIDTH-1:0] net_word;

  assign mode = rot_i ? MODE_ROTATE : MODE_SHIFT;

  xbar_amt_decoder #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .amt_i       (amt_i),
    .mode_i      (mode),
    .vec_o       (dec_vec),
    .range_err_o (dec_range_err)
  );

  assign sel_used = use_dec_i ? dec_vec : sel_i;

  xbar_sel_check #(.WIDTH(WIDTH)) u_chk (
    .vec_i    (sel_used),
    .mode_i   (mode),
    .sel_ok_o (sel_ok)
  );

  xbar_diag_array #(.WIDTH(WIDTH)) u_arr (
    .data_i (data_i),
    .lit_i  (lit_i),
    .sel_i  (sel_used),
    .mode_i (mode),
    .net_o  (net_word)
  );

  assign err_o  = !sel_ok || (use_dec_i && dec_range_err);
  assign data_o = err_o ? '0 : net_word;

  // R5: an error never lets data through
  assert_zero_on_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (data_o == '0));

  // R3: the centre diagonal is an identity in shift mode
  assert_centre_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rot_i && !err_o && sel_used[ZERO_LINE]) |-> (data_o == data_i));

  // R1: one place left, bit 0 from the literal
  assert_left_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rot_i && !err_o && sel_used[ZERO_LINE+1]) |->
      (data_o[WIDTH-1:1] == data_i[WIDTH-2:0]) && (data_o[0] == lit_i[0]));

  // R2: one place right, top bit from the literal
  assert_right_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rot_i && !err_o && sel_used[ZERO_LINE-1]) |->
      (data_o[WIDTH-2:0] == data_i[WIDTH-1:1]) && (data_o[WIDTH-1] == lit_i[WIDTH-1]));

  // R4: a rotation neither gains nor loses set bits
  assert_rot_popcount_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_i && !err_o) |-> ($countones(data_o) == $countones(data_i)));

  // R7: an out-of-range decoded amount always reaches the error output
  assert_dec_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (use_dec_i && dec_range_err) |-> err_o);
endmodule

// File: tb/test_xbar_diag_shifter.sv
module test_xbar_diag_shifter;
  localparam int W  = 8;
  localparam int AW = 5;
  localparam int NV = 14;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [W-1:0]         data_i, lit_i;
  logic                 rot_i, use_dec_i;
  logic [2*W-2:0]       sel_i;
  logic signed [AW-1:0] amt_i;
  logic [W-1:0]         data_o;
  logic                 err_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  xbar_diag_shifter #(.WIDTH(W), .AMT_W(AW)) i_xbar_diag_shifter (
    .clk(clk), .rst_n(rst_n), .data_i(data_i), .lit_i(lit_i), .rot_i(rot_i),
    .use_dec_i(use_dec_i), .sel_i(sel_i), .amt_i(amt_i),
    .data_o(data_o), .err_o(err_o)
  );

  // Entry layout: {rot, sel[14:0], data, lit, expected data, expected err}
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 15'h0080, 8'hA5, 8'h00, 8'hA5, 1'b0},  // R3 centre line
    {1'b0, 15'h0100, 8'h81, 8'h00, 8'h02, 1'b0},  // R1 left 1
    {1'b0, 15'h0400, 8'h81, 8'hFF, 8'h0F, 1'b0},  // R1 left 3, literal fill
    {1'b0, 15'h4000, 8'h01, 8'h00, 8'h80, 1'b0},  // R1 left 7
    {1'b0, 15'h0020, 8'h81, 8'h00, 8'h20, 1'b0},  // R2 right 2
    {1'b0, 15'h0020, 8'h81, 8'hFF, 8'hE0, 1'b0},  // R2 right 2, literal fill
    {1'b0, 15'h0001, 8'h80, 8'hAA, 8'hAB, 1'b0},  // R2 right 7
    {1'b1, 15'h0008, 8'h81, 8'h00, 8'h0C, 1'b0},  // R4 rotate 3
    {1'b1, 15'h0001, 8'h3C, 8'hFF, 8'h3C, 1'b0},  // R4 rotate 0
    {1'b1, 15'h0080, 8'h01, 8'h00, 8'h80, 1'b0},  // R4 rotate 7
    {1'b1, 15'h0002, 8'h80, 8'hFF, 8'h01, 1'b0},  // R4 literal ignored
    {1'b0, 15'h0000, 8'hFF, 8'hFF, 8'h00, 1'b1},  // R5 no line
    {1'b0, 15'h0180, 8'hFF, 8'h00, 8'h00, 1'b1},  // R5 two lines
    {1'b1, 15'h0100, 8'hFF, 8'h00, 8'h00, 1'b1}   // R5 rotate with upper line
  };

  task automatic check(input string req, input logic [W-1:0] exp_d, input logic exp_e);
    n_checks++;
    if (data_o !== exp_d || err_o !== exp_e) begin
      n_fails++;
      $display("FAIL %s: data_o=%h err_o=%b expected data_o=%h err_o=%b",
               req, data_o, err_o, exp_d, exp_e);
    end
  endtask

  function automatic logic [W-1:0] ref_shift(input int a, input logic [W-1:0] d,
                                             input logic [W-1:0] l);
    logic [W-1:0] low_mask;
    if (a >= 0) begin
      low_mask = (8'd1 << a) - 8'd1;
      return (d << a) | (l & low_mask);
    end
    return (d >> (-a)) | (l & ~(8'hFF >> (-a)));
  endfunction

  function automatic logic [W-1:0] ref_rotate(input int a, input logic [W-1:0] d);
    logic [2*W-1:0] both;
    int r;
    r = (a < 0) ? a + W : a;
    both = {d, d} << r;
    return both[2*W-1:W];
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b1; data_i = 8'h5A; lit_i = 8'hFF; rot_i = 1'b0;
    use_dec_i = 1'b1; sel_i = '0; amt_i = 5'sd3;
    #2 rst_n = 1'b0;
    #8 check("R8 reset amount zero", 8'h5A, 1'b0);
    repeat (2) @(posedge clk);
    #5 check("R8 held across clock edges", 8'h5A, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    // External select table; each result sampled before any clock edge (R9)
    use_dec_i = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {rot_i, sel_i, data_i, lit_i} = VEC[i][40:9];
      #5 check($sformatf("R9 table entry %0d", i), VEC[i][8:1], VEC[i][0]);
    end

    // R9: a select change alone, mid-cycle, reaches the output
    @(negedge clk);
    rot_i = 1'b0; data_i = 8'hC3; lit_i = 8'h00; sel_i = 15'h0080;
    #3 check("R9 before change", 8'hC3, 1'b0);
    sel_i = 15'h0200;
    #3 check("R9 after change, R1 left 2", 8'h0C, 1'b0);

    // R6/R7: decoded amounts, shift then rotate mode
    use_dec_i = 1'b1; sel_i = 15'h7FFF; data_i = 8'hB4; lit_i = 8'h5C;
    for (int m = 0; m < 2; m++) begin
      for (int a = -10; a <= 10; a++) begin
        @(negedge clk);
        rot_i = (m == 1);
        amt_i = AW'(a);
        @(posedge clk);
        #5;
        if (a < -(W-1) || a > W-1)
          check($sformatf("R7 amount %0d mode %0d", a, m), 8'h00, 1'b1);
        else if (m == 0)
          check($sformatf("R6 shift amount %0d", a), ref_shift(a, data_i, lit_i), 1'b0);
        else
          check($sformatf("R6 rotate amount %0d", a), ref_rotate(a, data_i), 1'b0);
      end
    end

    // R6: one-cycle latency, old amount still acts before the edge
    @(negedge clk);
    rot_i = 1'b0; amt_i = 5'sd1;
    @(posedge clk);
    @(negedge clk) amt_i = 5'sd2;
    #3 check("R6 before capture", ref_shift(1, 8'hB4, 8'h5C), 1'b0);
    @(posedge clk);
    #5 check("R6 after capture", ref_shift(2, 8'hB4, 8'h5C), 1'b0);

    finish_run();
  end
endmodule